// File: doc/BRIEF.md
# Audio Codec Transfer-Control Register Unit

This unit sits behind the host interface of a stereo audio codec. It holds two control registers that the host reaches through a 4-bit indirect index. The configuration register at index 9 selects how each direction moves data. Each direction can be enabled or disabled, and each can use DMA or programmed I/O. Playback and capture can run on separate DMA lines, or share the playback line. The pin register at index 10 holds the interrupt enable and two general-purpose output pins.

The host opens a mode-change window through the `mce_i` level. Outside that window, a write to index 9 changes only the two direction-enable bits. The converters, FIFOs, sample counter and calibration engine are outside this unit. They appear here only as one-cycle strobes:
- ready-for-sample, one per direction;
- count-reached;
- a power-down level.

From these inputs the unit derives three things:
- the two DMA request lines;
- a sticky interrupt, cleared by a one-cycle clear input;
- a one-cycle calibration start pulse when autocalibration is enabled.

Top module: `xfer_ctl_regs`

## Requirements
- R1: After a synchronous active-low reset, index 9 reads 8'h08 (autocalibrate enable set) and index 10 reads 8'h00. All outputs are low.
- R2: A write to index 9 with `mce_i` low updates only bit0 (playback enable) and bit1 (capture enable). Bit2 (single channel), bit3 (autocalibrate), bit6 (playback PIO) and bit7 (capture PIO) keep their values. With `mce_i` high, all of these bits take the written value.
- R3: These bits always read as zero and ignore writes: index 9 bits 5:4, and index 10 bits 5:2 and bit0. Any index other than 9 or 10 reads as 8'h00.
- R4: A ready strobe on `play_rdy_i` (or `cap_rdy_i`) in cycle N raises the matching request line in cycle N+1, if three conditions hold: the direction's enable bit is 1, its PIO bit is 0, and single-channel mode is off.
- R5: A direction whose PIO bit (bit6 playback, bit7 capture) is 1 never raises a DMA request.
- R6: With single-channel mode on (index 9 bit2 = 1), `cap_req_o` stays low and a permitted capture request appears on `play_req_o`.
- R7: With single-channel mode on and both enable bits set, capture strobes are suppressed and only playback strobes produce requests.
- R8: A request line falls in the cycle after the clock edge that clears its direction's enable bit, even while the ready strobe stays high.
- R9: `xctl_o[1]` follows index 10 bit7 and `xctl_o[0]` follows index 10 bit6. Index 10 is writable whatever the level of `mce_i`.
- R10: `irq_o` rises in the cycle after `cnt_done_i` is seen with index 10 bit1 (interrupt enable) set. It stays high until `irq_clr_i` is seen. If set and clear arrive together, the set wins. A count-reached strobe with interrupt enable clear has no effect.
- R11: `cal_start_o` pulses high for one cycle, in the cycle after `mce_i` or `pwrdn_i` falls, provided autocalibrate enable is 1. With autocalibrate enable 0 it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mce_i | input | 1 | Mode-change window open |
| pwrdn_i | input | 1 | Power-down level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_idx_i | input | 4 | Indirect register index |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the indexed register |
| play_rdy_i | input | 1 | Playback sample-ready strobe |
| cap_rdy_i | input | 1 | Capture sample-ready strobe |
| cnt_done_i | input | 1 | Sample count reached strobe |
| irq_clr_i | input | 1 | Interrupt clear strobe |
| play_req_o | output | 1 | Playback DMA request line |
| cap_req_o | output | 1 | Capture DMA request line |
| xctl_o | output | 2 | General-purpose control pins |
| irq_o | output | 1 | Interrupt, active high |
| cal_start_o | output | 1 | Calibration start pulse |

## Verification
The bench builds the unit with its default parameters: a 4-bit index, the configuration register at 9 and the pin register at 10. With these values, writes and reads can land on both live registers and on unused indices, which exercises the zero-read decode. All three request routings are reached by reprogramming the configuration register between directed sequences: dual-channel, single-channel, and single-channel with playback priority. The same approach reaches the gated write path, the sticky interrupt, and both calibration triggers.

// File: rtl/xfer_ctl_pkg.sv
// Package: shared types and field layout for the transfer-control unit.
// Assumes an 8-bit register data path.
package xfer_ctl_pkg;
    localparam int DATA_W = 8;

    // Bit positions in the configuration register (host-visible layout).
    localparam int B_PEN  = 0;
    localparam int B_CEN  = 1;
    localparam int B_SDC  = 2;
    localparam int B_ACAL = 3;
    localparam int B_PPIO = 6;
    localparam int B_CPIO = 7;

    // Bit positions in the pin register.
    localparam int B_IEN   = 1;
    localparam int B_XCTL0 = 6;
    localparam int B_XCTL1 = 7;

    typedef struct packed {
        logic cap_pio;
        logic play_pio;
        logic auto_cal;
        logic single_ch;
        logic cap_en;
        logic play_en;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{auto_cal: 1'b1, default: 1'b0};
endpackage

// File: rtl/xfer_ctl_regfile.sv
// Module: holds the configuration and pin registers behind an indirect index.
// Assumes one write strobe per cycle. Reserved bits are not stored and read as zero.
module xfer_ctl_regfile
    import xfer_ctl_pkg::*;
#(
    parameter int IDX_W   = 4,
    parameter int CFG_IDX = 9,
    parameter int PIN_IDX = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mce,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output cfg_t              cfg,
    output logic              ien,
    output logic [1:0]        xctl
);
    localparam logic [IDX_W-1:0] CFG_SEL = IDX_W'(CFG_IDX);
    localparam logic [IDX_W-1:0] PIN_SEL = IDX_W'(PIN_IDX);

    logic cfg_hit, pin_hit;
    assign cfg_hit = wr && (idx == CFG_SEL);
    assign pin_hit = wr && (idx == PIN_SEL);

    // Configuration register: enables always writable, rest only in mode-change window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= CFG_RESET;
        end else if (cfg_hit) begin
            cfg.play_en <= wdata[B_PEN];
            cfg.cap_en  <= wdata[B_CEN];
            if (mce) begin
                cfg.single_ch <= wdata[B_SDC];
                cfg.auto_cal  <= wdata[B_ACAL];
                cfg.play_pio  <= wdata[B_PPIO];
                cfg.cap_pio   <= wdata[B_CPIO];
            end
        end
    end

    // Pin register: interrupt enable and the two control pins, never protected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien  <= 1'b0;
            xctl <= 2'b00;
        end else if (pin_hit) begin
            ien  <= wdata[B_IEN];
            xctl <= {wdata[B_XCTL1], wdata[B_XCTL0]};
        end
    end

    // Read mux: rebuild the host layout, zeros in reserved and unknown positions.
    always_comb begin
        rdata = '0;
        if (idx == CFG_SEL) begin
            rdata[B_PEN]  = cfg.play_en;
            rdata[B_CEN]  = cfg.cap_en;
            rdata[B_SDC]  = cfg.single_ch;
            rdata[B_ACAL] = cfg.auto_cal;
            rdata[B_PPIO] = cfg.play_pio;
            rdata[B_CPIO] = cfg.cap_pio;
        end else if (idx == PIN_SEL) begin
            rdata[B_IEN]   = ien;
            rdata[B_XCTL0] = xctl[0];
            rdata[B_XCTL1] = xctl[1];
        end
    end

    // R2: protected fields hold across a write made outside the window.
    p_protect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hit && !mce) |=> ({cfg.cap_pio, cfg.play_pio, cfg.auto_cal, cfg.single_ch}
                               == $past({cfg.cap_pio, cfg.play_pio, cfg.auto_cal, cfg.single_ch})));

    // R9: the control pins move only on a write to the pin register.
    p_pins_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_hit |=> $stable(xctl));
endmodule

// File: rtl/xfer_ctl_route.sv
// Module: turns ready strobes and configuration into the two DMA request lines.
// Assumes strobes are synchronous to clk; requests follow the registered strobe.
module xfer_ctl_route
    import xfer_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cfg_t cfg,
    input  logic play_rdy,
    input  logic cap_rdy,
    output logic play_req,
    output logic cap_req
);
    logic play_rdy_q, cap_rdy_q;
    logic play_ok, cap_ok, cap_shared;

    // Strobe capture: one register stage between the sample logic and the lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            play_rdy_q <= 1'b0;
            cap_rdy_q  <= 1'b0;
        end else begin
            play_rdy_q <= play_rdy;
            cap_rdy_q  <= cap_rdy;
        end
    end

    // Routing: per-direction permission, then single-channel merge with playback priority.
    always_comb begin
        play_ok    = cfg.play_en && !cfg.play_pio;
        cap_ok     = cfg.cap_en && !cfg.cap_pio;
        cap_shared = cfg.single_ch && cap_ok && !cfg.play_en && cap_rdy_q;
        play_req   = (play_rdy_q && play_ok) || cap_shared;
        cap_req    = !cfg.single_ch && cap_ok && cap_rdy_q;
    end

    // R6: the capture line stays low whenever the channels are merged.
    p_capline_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.single_ch |-> !cap_req);

    // R4: no request without a strobe from the previous cycle.
    p_norq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!play_rdy_q && !cap_rdy_q) |-> (!play_req && !cap_req));

    // R5: a direction in PIO mode never raises its own line.
    p_pio_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.cap_pio && !cfg.single_ch) |-> !cap_req);
endmodule

// File: rtl/xfer_ctl_event.sv
// Module: sticky interrupt and calibration start pulse.
// Assumes mce and pwrdn are synchronous levels; a falling edge is seen over one clock.
module xfer_ctl_event (
    input  logic clk,
    input  logic rst_n,
    input  logic ien,
    input  logic auto_cal,
    input  logic cnt_done,
    input  logic irq_clr,
    input  logic mce,
    input  logic pwrdn,
    output logic irq,
    output logic cal_start
);
    logic mce_q, pwrdn_q;

    // Interrupt flag: set by an enabled count strobe (set wins), cleared by the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                irq <= 1'b0;
        else if (cnt_done && ien)  irq <= 1'b1;
        else if (irq_clr)          irq <= 1'b0;
    end

    // Edge detect and calibration pulse on leaving the window or leaving power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mce_q     <= 1'b0;
            pwrdn_q   <= 1'b0;
            cal_start <= 1'b0;
        end else begin
            mce_q     <= mce;
            pwrdn_q   <= pwrdn;
            cal_start <= auto_cal && ((mce_q && !mce) || (pwrdn_q && !pwrdn));
        end
    end

    // R10: the flag holds until a clear arrives.
    p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    // R10: a clear without a concurrent enabled strobe drops the flag.
    p_irq_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !(cnt_done && ien)) |=> !irq);

    // R11: a pulse needs autocalibrate enabled in the previous cycle.
    p_cal_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |-> $past(auto_cal));
endmodule

// File: rtl/xfer_ctl_regs.sv
// Module: top of the codec transfer-control unit; wires register file, routing and events.
// Assumes all inputs are synchronous to clk.
module xfer_ctl_regs
    import xfer_ctl_pkg::*;
#(
    parameter int IDX_W   = 4,
    parameter int CFG_IDX = 9,
    parameter int PIN_IDX = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mce_i,
    input  logic              pwrdn_i,
    input  logic              reg_wr_i,
    input  logic [IDX_W-1:0]  reg_idx_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              play_rdy_i,
    input  logic              cap_rdy_i,
    input  logic              cnt_done_i,
    input  logic              irq_clr_i,
    output logic              play_req_o,
    output logic              cap_req_o,
    output logic [1:0]        xctl_o,
    output logic              irq_o,
    output logic              cal_start_o
);
    cfg_t cfg;
    logic ien;

    xfer_ctl_regfile #(
        .IDX_W  (IDX_W),
        .CFG_IDX(CFG_IDX),
        .PIN_IDX(PIN_IDX)
    ) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .mce  (mce_i),
        .wr   (reg_wr_i),
        .idx  (reg_idx_i),
        .wdata(reg_wdata_i),
        .rdata(reg_rdata_o),
        .cfg  (cfg),
        .ien  (ien),
        .xctl (xctl_o)
    );

    xfer_ctl_route u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg),
        .play_rdy(play_rdy_i),
        .cap_rdy (cap_rdy_i),
        .play_req(play_req_o),
        .cap_req (cap_req_o)
    );

    xfer_ctl_event u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ien      (ien),
        .auto_cal (cfg.auto_cal),
        .cnt_done (cnt_done_i),
        .irq_clr  (irq_clr_i),
        .mce      (mce_i),
        .pwrdn    (pwrdn_i),
        .irq      (irq_o),
        .cal_start(cal_start_o)
    );
endmodule

// File: tb/test_xfer_ctl_regs.sv
module test_xfer_ctl_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mce_i = 1'b0, pwrdn_i = 1'b0, reg_wr_i = 1'b0;
    logic [3:0] reg_idx_i = '0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       play_rdy_i = 1'b0, cap_rdy_i = 1'b0, cnt_done_i = 1'b0, irq_clr_i = 1'b0;
    logic       play_req_o, cap_req_o, irq_o, cal_start_o;
    logic [1:0] xctl_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xfer_ctl_regs i_xfer_ctl_regs (
        .clk(clk), .rst_n(rst_n), .mce_i(mce_i), .pwrdn_i(pwrdn_i),
        .reg_wr_i(reg_wr_i), .reg_idx_i(reg_idx_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .play_rdy_i(play_rdy_i), .cap_rdy_i(cap_rdy_i),
        .cnt_done_i(cnt_done_i), .irq_clr_i(irq_clr_i), .play_req_o(play_req_o),
        .cap_req_o(cap_req_o), .xctl_o(xctl_o), .irq_o(irq_o), .cal_start_o(cal_start_o)
    );

    // {mce, index, write data, expected read-back}
    localparam logic [20:0] VEC [10] = '{
        {1'b0, 4'd9,  8'hFF, 8'h0B},   // R2 only enables change
        {1'b1, 4'd9,  8'hFF, 8'hCF},   // R2/R3 full write, reserved zero
        {1'b0, 4'd9,  8'h00, 8'hCC},   // R2 enables cleared, rest kept
        {1'b1, 4'd9,  8'h41, 8'h41},   // R2
        {1'b1, 4'd10, 8'hFF, 8'hC2},   // R3 pin register reserved zero
        {1'b0, 4'd10, 8'h40, 8'h40},   // R9 not protected
        {1'b0, 4'd9,  8'h8A, 8'h42},   // R2 protected bits kept
        {1'b1, 4'd9,  8'h08, 8'h08},   // R2
        {1'b1, 4'd3,  8'hFF, 8'h00},   // R3 unused index
        {1'b0, 4'd15, 8'hA5, 8'h00}    // R3 unused index
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic m, input logic [3:0] i, input logic [7:0] d);
        mce_i = m; reg_idx_i = i; reg_wdata_i = d; reg_wr_i = 1'b1;
        step();
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(input string req, input logic [3:0] i, input logic [7:0] exp);
        reg_idx_i = i;
        #0.5;
        check(req, reg_rdata_o, exp);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        #0.5;
        // R1 reset state
        rd("R1 idx9", 4'd9, 8'h08);
        rd("R1 idx10", 4'd10, 8'h00);
        check("R1 outputs", {3'b0, play_req_o, cap_req_o, irq_o, cal_start_o, |xctl_o}, 8'h00);

        // Table walk: write then read back
        for (int k = 0; k < 10; k++) begin
            logic m; logic [3:0] i; logic [7:0] d, e;
            {m, i, d, e} = VEC[k];
            wr(m, i, d);
            rd($sformatf("R2/R3 vec %0d", k), i, e);
        end
        mce_i = 1'b0; step(); step();

        // R9 control pins
        wr(1'b0, 4'd10, 8'hC0); check("R9 both high", {6'b0, xctl_o}, 8'h03);
        wr(1'b0, 4'd10, 8'h40); check("R9 bit6 only", {6'b0, xctl_o}, 8'h01);
        wr(1'b0, 4'd10, 8'h80); check("R9 bit7 only", {6'b0, xctl_o}, 8'h02);

        // R4 dual channel DMA
        mce_i = 1'b1; step();
        wr(1'b1, 4'd9, 8'h03);
        play_rdy_i = 1'b1; step(); play_rdy_i = 1'b0;
        check("R4 play req", {6'b0, play_req_o, cap_req_o}, 8'h02);
        step(); check("R4 play drop", {6'b0, play_req_o, cap_req_o}, 8'h00);
        cap_rdy_i = 1'b1; step(); cap_rdy_i = 1'b0;
        check("R4 cap req", {6'b0, play_req_o, cap_req_o}, 8'h01);
        step();

        // R5 PIO suppresses
        wr(1'b1, 4'd9, 8'hC3);
        play_rdy_i = 1'b1; cap_rdy_i = 1'b1; step(); play_rdy_i = 1'b0; cap_rdy_i = 1'b0;
        check("R5 pio", {6'b0, play_req_o, cap_req_o}, 8'h00);
        step();

        // R6 single channel, capture only
        wr(1'b1, 4'd9, 8'h06);
        cap_rdy_i = 1'b1; step(); cap_rdy_i = 1'b0;
        check("R6 cap on play line", {6'b0, play_req_o, cap_req_o}, 8'h02);
        step();

        // R7 single channel, both enabled
        wr(1'b1, 4'd9, 8'h07);
        cap_rdy_i = 1'b1; step(); cap_rdy_i = 1'b0;
        check("R7 cap suppressed", {6'b0, play_req_o, cap_req_o}, 8'h00);
        play_rdy_i = 1'b1; step(); play_rdy_i = 1'b0;
        check("R7 play wins", {6'b0, play_req_o, cap_req_o}, 8'h02);
        step();

        // R8 disable drops request with strobe held
        wr(1'b1, 4'd9, 8'h01);
        play_rdy_i = 1'b1; step();
        check("R8 before", {7'b0, play_req_o}, 8'h01);
        wr(1'b0, 4'd9, 8'h00);
        check("R8 after", {7'b0, play_req_o}, 8'h00);
        play_rdy_i = 1'b0;

        // R10 interrupt
        wr(1'b0, 4'd10, 8'h00);
        cnt_done_i = 1'b1; step(); cnt_done_i = 1'b0;
        check("R10 disabled", {7'b0, irq_o}, 8'h00);
        wr(1'b0, 4'd10, 8'h02);
        cnt_done_i = 1'b1; step(); cnt_done_i = 1'b0;
        check("R10 set", {7'b0, irq_o}, 8'h01);
        step(); step();
        check("R10 held", {7'b0, irq_o}, 8'h01);
        irq_clr_i = 1'b1; cnt_done_i = 1'b1; step();
        check("R10 set wins", {7'b0, irq_o}, 8'h01);
        cnt_done_i = 1'b0; step(); irq_clr_i = 1'b0;
        check("R10 cleared", {7'b0, irq_o}, 8'h00);

        // R11 calibration pulse on leaving the window (acal currently 0)
        mce_i = 1'b1; step(); step();
        mce_i = 1'b0; step();
        check("R11 no acal", {7'b0, cal_start_o}, 8'h00);
        wr(1'b1, 4'd9, 8'h08);
        step();
        mce_i = 1'b0; step();
        check("R11 mce pulse", {7'b0, cal_start_o}, 8'h01);
        step();
        check("R11 one cycle", {7'b0, cal_start_o}, 8'h00);
        pwrdn_i = 1'b1; step(); step();
        pwrdn_i = 1'b0; step();
        check("R11 pwrdn pulse", {7'b0, cal_start_o}, 8'h01);
        step();
        check("R11 pwrdn end", {7'b0, cal_start_o}, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule